// File: doc/BRIEF.md
# Cascadable Prescaled Timer Bank

A bank of four 16-bit up-counters. Each one is driven by the system clock through a selectable divider, or by the overflow of the counter one index below it. A counter that wraps past its maximum reloads from a stored start value. It can raise a one-cycle interrupt pulse. It also passes the wrap upward in the same clock edge, so a chain of counters acts as one wider counter. Wraps of the two lowest counters are also exported as one-cycle refill strobes, which pace an audio sample FIFO outside the block.

Software reaches the bank through a flat 16-bit register port. The port selects a counter by index. A half-select bit picks either the live count (low half) or the control word (high half). Writes take effect at the next clock edge. Reads are combinational.

Top module: `tmr_bank`

## Requirements
- R1: After synchronous reset every count, reload value and control word reads 0, and `irq_pulse` and `fifo_tick` are 0.
- R2: The control word keeps only bit 7 (enable), bit 6 (interrupt enable), bit 2 (cascade) and bits 1:0 (divider select). All other bits read back as 0.
- R3: A write to the low half loads the count and the reload value at the same edge. Such a write takes priority over an increment in that cycle.
- R4: The divider select maps 0, 1, 2 and 3 to division by 1, 64, 256 and 1024. The first increment comes one full division period after the enabling write, and each later increment comes one period after the previous one.
- R5: When an enabled counter at 0xFFFF receives an increment, it loads its reload value instead of 0.
- R6: For exactly the one cycle after a wrap, `irq_pulse[i]` is 1, but only if the counter's interrupt enable bit is set. Bit i corresponds to interrupt line i+8.
- R7: A counter with its cascade bit set ignores the divider and increments at the same edge at which counter i-1 wraps. Counter 0 has nothing below it, so with cascade set it never counts.
- R8: `fifo_tick[i]`, for i of 0 or 1, is 1 for exactly the one cycle after counter i wraps, whatever the interrupt enable bit is.
- R9: A counter whose enable bit is clear holds its count.
- R10: `bus_sel` picks the counter and `bus_hi` picks the half. A read or write touches only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_sel | input | 2 | Counter index |
| bus_hi | input | 1 | 0 selects the count/reload, 1 selects the control word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| irq_pulse | output | 4 | Per-counter interrupt pulse on wrap |
| fifo_tick | output | 2 | Refill strobes from wraps of counters 0 and 1 |

## Verification
A register write lands at the edge that samples it. From then on, a counter with division D shows floor(k/D) increments after k more edges. Its wrap pulses, both the interrupt and the FIFO strobe, appear in the cycle right after the edge at which the count reloads. A cascaded counter moves at the same edge as the wrap below it. The bench drives all inputs on falling edges and counts elapsed falling edges from the enabling write. It samples shortly after each falling edge, so every expected value is fixed by that edge count. Pulse checks sample the cycle before, the cycle of and the cycle after each expected pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef struct packed {
        logic       en;
        logic       ie;
        logic       casc;
        logic [1:0] psel;
    } tmr_ctl_t;

    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_IE_BIT   = 6;
    localparam int CTL_CASC_BIT = 2;

    function automatic tmr_ctl_t ctl_unpack(input logic [7:0] w);
        tmr_ctl_t c;
        c.en   = w[CTL_EN_BIT];
        c.ie   = w[CTL_IE_BIT];
        c.casc = w[CTL_CASC_BIT];
        c.psel = w[1:0];
        return c;
    endfunction

    function automatic logic [7:0] ctl_pack(input tmr_ctl_t c);
        logic [7:0] w;
        w = '0;
        w[CTL_EN_BIT]   = c.en;
        w[CTL_IE_BIT]   = c.ie;
        w[CTL_CASC_BIT] = c.casc;
        w[1:0]          = c.psel;
        return w;
    endfunction

    // log2 of the division ratio for each select code
    function automatic int unsigned psel_shift(input logic [1:0] s);
        case (s)
            2'd0:    return 0;
            2'd1:    return 6;
            2'd2:    return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PS_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] psel,
    output logic       tick
);

    logic [PS_W-1:0] pcnt;
    logic [PS_W:0]   full;
    logic [PS_W-1:0] last;

    always_comb begin
        full = (PS_W+1)'(1) << psel_shift(psel);
        last = PS_W'(full - 1'b1);
        tick = en && (pcnt >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || !en || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cnt,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wr_val,
    input  tmr_ctl_t         ctl_new,
    input  logic             ps_tick,
    input  logic             lower_ovf,
    output tmr_ctl_t         ctl,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             irq
);

    logic [CNT_W-1:0] reload;
    logic             inc;

    always_comb begin
        inc = ctl.en && (ctl.casc ? lower_ovf : ps_tick);
        ovf = inc && (&cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            cnt    <= '0;
            reload <= '0;
            irq    <= 1'b0;
        end else begin
            if (wr_ctl)
                ctl <= ctl_new;
            if (wr_cnt) begin
                cnt    <= wr_val;
                reload <= wr_val;
            end else if (ovf) begin
                cnt <= reload;
            end else if (inc) begin
                cnt <= cnt + 1'b1;
            end
            irq <= ovf && ctl.ie;
        end
    end

    assert_reload_on_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !wr_cnt) |=> (cnt == $past(reload)));

    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !wr_cnt) |=> $stable(cnt));

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ctl.ie));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int TMR_N  = 4,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 10,
    parameter int FIFO_N = 2,
    localparam int SEL_W = $clog2(TMR_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic              bus_hi,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [TMR_N-1:0]  irq_pulse,
    output logic [FIFO_N-1:0] fifo_tick
);

    tmr_ctl_t         ctl_a  [TMR_N];
    logic [CNT_W-1:0] cnt_a  [TMR_N];
    logic [TMR_N-1:0] ovf;
    logic [TMR_N-1:0] tick;
    logic [TMR_N-1:0] wr_cnt;
    logic [TMR_N-1:0] wr_ctl;
    tmr_ctl_t         ctl_new;

    assign ctl_new = ctl_unpack(bus_wdata[7:0]);

    for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
        logic lower;
        if (i == 0) begin : g_base
            assign lower = 1'b0;
        end else begin : g_link
            assign lower = ovf[i-1];
        end

        assign wr_cnt[i] = bus_wr && !bus_hi && (bus_sel == SEL_W'(i));
        assign wr_ctl[i] = bus_wr &&  bus_hi && (bus_sel == SEL_W'(i));

        tmr_prescaler #(.PS_W(PS_W)) u_ps (
            .clk  (clk),
            .rst  (rst),
            .en   (ctl_a[i].en && !ctl_a[i].casc),
            .psel (ctl_a[i].psel),
            .tick (tick[i])
        );

        tmr_unit #(.CNT_W(CNT_W)) u_unit (
            .clk       (clk),
            .rst       (rst),
            .wr_cnt    (wr_cnt[i]),
            .wr_ctl    (wr_ctl[i]),
            .wr_val    (bus_wdata),
            .ctl_new   (ctl_new),
            .ps_tick   (tick[i]),
            .lower_ovf (lower),
            .ctl       (ctl_a[i]),
            .cnt       (cnt_a[i]),
            .ovf       (ovf[i]),
            .irq       (irq_pulse[i])
        );

        if (i > 0) begin : g_chk
            assert_cascade_step_R7: assert property (@(posedge clk) disable iff (rst)
                (ctl_a[i].en && ctl_a[i].casc && ovf[i-1] && !wr_cnt[i])
                |=> (cnt_a[i] != $past(cnt_a[i])));
        end else begin : g_chk0
            assert_base_cascade_idle_R7: assert property (@(posedge clk) disable iff (rst)
                (ctl_a[0].casc && !wr_cnt[0]) |=> $stable(cnt_a[0]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            fifo_tick <= '0;
        else
            fifo_tick <= ovf[FIFO_N-1:0];
    end

    always_comb begin
        if (bus_hi)
            bus_rdata = CNT_W'(ctl_pack(ctl_a[bus_sel]));
        else
            bus_rdata = cnt_a[bus_sel];
    end

endmodule

// File: tb/tmr_bank_bench.sv
`timescale 1ns/100ps
module tmr_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = '0;
    logic        bus_hi = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq_pulse;
    logic [1:0]  fifo_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_bank u_tmr_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_hi    (bus_hi),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse),
        .fifo_tick (fifo_tick)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int s, input bit h, input logic [15:0] v);
        @(negedge clk);
        bus_sel = 2'(s); bus_hi = h; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int s, input bit h, output logic [15:0] v);
        bus_sel = 2'(s); bus_hi = h;
        #0.2;
        v = bus_rdata;
    endtask

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int t = 0; t < 4; t++) begin
            rd(t, 0, v); chk("R1 count", v, 16'h0);
            rd(t, 1, v); chk("R1 ctl", v, 16'h0);
        end
        chk("R1 outputs", {10'h0, irq_pulse, fifo_tick}, 16'h0);

        // R2 control layout
        wr(3, 1, 16'hFFFF);
        rd(3, 1, v); chk("R2 ctl mask", v, 16'h00C7);
        wr(3, 1, 16'h0000);

        // R3 / R9 / R10 data write, hold, isolation
        wr(1, 0, 16'h1234);
        rd(1, 0, v); chk("R3 data write", v, 16'h1234);
        rd(0, 0, v); chk("R10 other timer", v, 16'h0000);
        repeat (5) @(negedge clk);
        rd(1, 0, v); chk("R9 disabled hold", v, 16'h1234);

        // R4 divider sweep on timer 2
        for (int p = 0; p < 4; p++) begin
            int d;
            int ks[3];
            int cur;
            d = (p == 0) ? 1 : (p == 1) ? 64 : (p == 2) ? 256 : 1024;
            ks[0] = d - 1; ks[1] = d; ks[2] = 3 * d + 1;
            wr(2, 0, 16'h0000);
            wr(2, 1, 16'(16'h0080 | p));
            cur = 0;
            for (int j = 0; j < 3; j++) begin
                repeat (ks[j] - cur) @(negedge clk);
                cur = ks[j];
                rd(2, 0, v);
                chk($sformatf("R4 div%0d k=%0d", d, ks[j]), v, 16'(ks[j] / d));
            end
            wr(2, 1, 16'h0000);
        end

        // R5 / R6 / R8 wrap on timer 0 with interrupt enabled
        wr(0, 0, 16'hFFF0);
        wr(0, 1, 16'h00C0);
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            if (k >= 15) begin
                logic e;
                e = (k == 16);
                rd(0, 0, v);
                chk($sformatf("R6 irq k=%0d", k), {15'h0, irq_pulse[0]}, {15'h0, e});
                chk($sformatf("R8 fifo0 k=%0d", k), {15'h0, fifo_tick[0]}, {15'h0, e});
                if (k == 16) chk("R5 reload", v, 16'hFFF0);
                if (k == 17) chk("R5 after reload", v, 16'hFFF1);
            end
        end
        wr(0, 1, 16'h0000);

        // R6 / R8 wrap on timer 1 without interrupt enable
        wr(1, 0, 16'hFFFC);
        wr(1, 1, 16'h0080);
        repeat (4) @(negedge clk);
        chk("R8 fifo1 no ie", {15'h0, fifo_tick[1]}, 16'h1);
        chk("R6 irq1 masked", {15'h0, irq_pulse[1]}, 16'h0);
        rd(1, 0, v); chk("R5 reload t1", v, 16'hFFFC);
        wr(1, 1, 16'h0000);

        // R7 cascade of timer 1 onto timer 0
        wr(1, 0, 16'hFFFD);
        wr(1, 1, 16'h0084);
        wr(0, 0, 16'hFFFE);
        wr(0, 1, 16'h0080);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 2) begin
                rd(1, 0, v); chk("R7 cascade same edge", v, 16'hFFFE);
                chk("R8 fifo0 chain", {15'h0, fifo_tick[0]}, 16'h1);
            end
            if (k == 6) begin
                rd(1, 0, v); chk("R7 cascade wrap", v, 16'hFFFD);
                chk("R8 fifo1 chain", {15'h0, fifo_tick[1]}, 16'h1);
            end
        end
        wr(0, 1, 16'h0000);
        wr(1, 1, 16'h0000);

        // R7 timer 0 with cascade never counts
        wr(0, 0, 16'h0005);
        wr(0, 1, 16'h0084);
        repeat (10) @(negedge clk);
        rd(0, 0, v); chk("R7 base cascade idle", v, 16'h0005);
        wr(0, 1, 16'h0000);

        // R3 write while running, R9 hold after disable
        wr(2, 0, 16'h0000);
        wr(2, 1, 16'h0080);
        repeat (5) @(negedge clk);
        rd(2, 0, v); chk("R4 running div1", v, 16'h0005);
        wr(2, 0, 16'h0100);
        rd(2, 0, v); chk("R3 write wins", v, 16'h0100);
        repeat (3) @(negedge clk);
        rd(2, 0, v); chk("R3 resume", v, 16'h0103);
        wr(2, 1, 16'h0000);
        rd(2, 0, v);
        begin
            logic [15:0] held;
            held = v;
            repeat (10) @(negedge clk);
            rd(2, 0, v); chk("R9 hold after disable", v, held);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule